// File: doc/BRIEF.md
# Hypervisor Instruction Trap Decision Unit

This unit takes an instruction that has already been classified by the decoder and decides what happens to it. There are three outcomes. The instruction executes normally, it is undefined at the current level, or it traps to the hypervisor level (EL2). When the outcome is a trap, the unit also supplies the exception syndrome class that the hypervisor handler will see. Opcode decoding happens upstream; this unit only sees a class code plus a few qualifiers.

The decision depends on several inputs:
- the current exception level;
- whether EL2 is enabled in the current security state;
- whether a secure-monitor level (EL3) is implemented;
- the hypervisor configuration word.

Wait-for-interrupt and wait-for-event instructions have extra qualifiers. They depend on the condition-code result, on whether the instruction would actually enter low power, and on the guest's own trap controls for these instructions. When more than one rule applies, a fixed priority picks the outcome. Undefined-at-EL0 comes first, then the hypervisor-call disable, then the EL2 traps, then normal execution. The verdict is computed combinationally from the request inputs and is registered, so it appears one clock after the request.

Top module: `hyp_trap_unit`

## Requirements
- R1: A request with `req_valid`=1 gives `out_valid`=1 on the next clock, with exactly one of `out_exec`, `out_undef`, `out_trap` set. With no request, `out_valid` and all three flags are 0.
  - Class codes: 0 WFI, 1 WFE, 2 SMC, 3 HVC, 4 TLB maintenance, 5 cache maintenance to PoU, 6 cache maintenance to PoC, 7 cache maintenance by set/way, 8 auxiliary control access, 9 virtual-memory control access, 10 ID group 0, 11 ID group 1, 12 ID group 2, 13 ID group 3 coprocessor read, 14 ID group 3 floating-point feature read.
  - `cur_el` holds the level number (0 to 3).
- R2: While reset is held, and on the first clock after it is released, all outputs are 0.
- R3: No trap is produced when `el2_enabled` is 0.
- R4: At EL0, every class except WFI, WFE and ID group 2 is undefined. This holds whatever the configuration bits are set to.
- R5: A WFI traps when config bit 13 is set. A WFE traps when config bit 14 is set.
  - The trap is taken only if all of the following hold: the level is EL0 or EL1, `cond_pass`=1, `lowpower_entry`=1, and the matching guest trap input (`guest_wfi_trap` or `guest_wfe_trap`) is 0.
  - Otherwise the instruction executes. The syndrome class is 0x01.
- R6: An SMC at EL1 traps with class 0x13 when config bit 19 is set and `el3_present`=1. An SMC at EL1 with `el3_present`=0 is undefined.
- R7: When `el3_present`=0 and config bit 29 is set, HVC is undefined at EL2, and also at EL1 when EL2 is enabled. When `el3_present`=1, bit 29 has no effect.
- R8: At EL1, a write to a virtual-memory control register traps when config bit 26 is set. A read traps when config bit 30 is set. The syndrome class is 0x03.
- R9: At EL1, the following classes trap with syndrome class 0x03 when their config bit is set:

  | Class | Config bit |
  |---|---|
  | TLB maintenance | 25 |
  | Cache maintenance to PoU | 24 |
  | Cache maintenance to PoC | 23 |
  | Cache maintenance by set/way | 22 |
  | Auxiliary control access | 21 |

- R10: At EL1, reads of ID group 0 (bit 15), group 1 (bit 16) and group 3 (bit 18) trap. Writes to these groups execute.
  - Group 3 floating-point feature reads report class 0x08.
  - All other ID traps report class 0x03.
- R11: With config bit 17 set, ID group 2 accesses trap with class 0x03. This covers reads at EL0 and EL1, and writes (to the cache-size selector).
- R12: At EL2 and EL3, every class other than HVC executes.
- R13: `out_ec` is 0 whenever `out_trap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A classified instruction is presented |
| insn_class | input | 4 | Instruction class code |
| is_write | input | 1 | Access is a register write |
| cond_pass | input | 1 | Instruction passed its condition check |
| lowpower_entry | input | 1 | WFx would otherwise enter low power |
| guest_wfi_trap | input | 1 | Guest's own WFI trap is active |
| guest_wfe_trap | input | 1 | Guest's own WFE trap is active |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | EL2 enabled in the current security state |
| el3_present | input | 1 | Secure-monitor level implemented |
| hyp_cfg | input | CFG_W | Hypervisor configuration word |
| out_valid | output | 1 | Verdict valid |
| out_exec | output | 1 | Execute normally |
| out_undef | output | 1 | Undefined at current level |
| out_trap | output | 1 | Trap to EL2 |
| out_ec | output | 6 | Syndrome class when trapping |

## Verification
The bench builds the unit with the default configuration width of 32 bits. This puts every control position up to bit 30 within reach, so each configuration bit can be set alone, or every bit at once, to test the priority ordering.

Each of the following gets its own stimulus:
- the WFx qualifiers (condition pass, low-power entry, the guest's own trap);
- the EL3-present flag, which flips both the SMC and the HVC rules;
- the EL2-enabled flag.

With these, each gate on the outcome is seen both open and closed.

// File: rtl/hyp_trap_pkg.sv
package hyp_trap_pkg;

    localparam int EC_W = 6;

    typedef enum logic [3:0] {
        CLS_WFI    = 4'd0,
        CLS_WFE    = 4'd1,
        CLS_SMC    = 4'd2,
        CLS_HVC    = 4'd3,
        CLS_TLB    = 4'd4,
        CLS_CM_POU = 4'd5,
        CLS_CM_POC = 4'd6,
        CLS_CM_SW  = 4'd7,
        CLS_AUXCTL = 4'd8,
        CLS_VMCTL  = 4'd9,
        CLS_ID0    = 4'd10,
        CLS_ID1    = 4'd11,
        CLS_ID2    = 4'd12,
        CLS_ID3_CP = 4'd13,
        CLS_ID3_FP = 4'd14,
        CLS_NONE   = 4'd15
    } insn_cls_e;

    // Positions of controls inside the configuration word
    localparam int POS_WFI_TRAP = 13;
    localparam int POS_WFE_TRAP = 14;
    localparam int POS_ID0      = 15;
    localparam int POS_ID1      = 16;
    localparam int POS_ID2      = 17;
    localparam int POS_ID3      = 18;
    localparam int POS_SMC_TRAP = 19;
    localparam int POS_AUX      = 21;
    localparam int POS_SETWAY   = 22;
    localparam int POS_POC      = 23;
    localparam int POS_POU      = 24;
    localparam int POS_TLB      = 25;
    localparam int POS_VM_WR    = 26;
    localparam int POS_HVC_OFF  = 29;
    localparam int POS_VM_RD    = 30;

    // Syndrome classes
    localparam logic [EC_W-1:0] EC_WFX   = 6'h01;
    localparam logic [EC_W-1:0] EC_CPREG = 6'h03;
    localparam logic [EC_W-1:0] EC_FPID  = 6'h08;
    localparam logic [EC_W-1:0] EC_SMC   = 6'h13;

    typedef struct packed {
        logic            valid;
        logic            exec;
        logic            undef;
        logic            trap;
        logic [EC_W-1:0] ec;
    } verdict_t;

endpackage

// File: rtl/hyp_trap_wfx.sv
module hyp_trap_wfx #(
    parameter int NK = 2
) (
    input  logic [NK-1:0] kind_sel,
    input  logic [NK-1:0] trap_en,
    input  logic [NK-1:0] guest_trap,
    input  logic          cond_pass,
    input  logic          lowpower_entry,
    output logic          wfx_trap
);
    logic [NK-1:0] hit;

    // One qualifier per wait kind
    for (genvar k = 0; k < NK; k++) begin : g_kind
        assign hit[k] = kind_sel[k] & trap_en[k] & ~guest_trap[k]
                      & cond_pass & lowpower_entry;
    end

    assign wfx_trap = |hit;
endmodule

// File: rtl/hyp_trap_sysreg.sv
module hyp_trap_sysreg
    import hyp_trap_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [3:0]       cls,
    input  logic             is_write,
    input  logic             el3_present,
    input  logic [CFG_W-1:0] cfg,
    output logic             grp_trap,
    output logic [EC_W-1:0]  grp_ec
);
    always_comb begin
        grp_trap = 1'b0;
        grp_ec   = EC_CPREG;
        unique case (insn_cls_e'(cls))
            CLS_SMC: begin
                grp_trap = cfg[POS_SMC_TRAP] & el3_present;
                grp_ec   = EC_SMC;
            end
            CLS_TLB:    grp_trap = cfg[POS_TLB];
            CLS_CM_POU: grp_trap = cfg[POS_POU];
            CLS_CM_POC: grp_trap = cfg[POS_POC];
            CLS_CM_SW:  grp_trap = cfg[POS_SETWAY];
            CLS_AUXCTL: grp_trap = cfg[POS_AUX];
            CLS_VMCTL:  grp_trap = is_write ? cfg[POS_VM_WR] : cfg[POS_VM_RD];
            CLS_ID0:    grp_trap = ~is_write & cfg[POS_ID0];
            CLS_ID1:    grp_trap = ~is_write & cfg[POS_ID1];
            CLS_ID2:    grp_trap = cfg[POS_ID2];
            CLS_ID3_CP: grp_trap = ~is_write & cfg[POS_ID3];
            CLS_ID3_FP: begin
                grp_trap = ~is_write & cfg[POS_ID3];
                grp_ec   = EC_FPID;
            end
            default: begin
                grp_trap = 1'b0;
                grp_ec   = EC_CPREG;
            end
        endcase
    end
endmodule

// File: rtl/hyp_trap_el0.sv
module hyp_trap_el0
    import hyp_trap_pkg::*;
(
    input  logic [3:0] cls,
    output logic       el0_undef
);
    // Only wait instructions and group-2 cache ID accesses are legal at EL0
    always_comb begin
        unique case (insn_cls_e'(cls))
            CLS_WFI, CLS_WFE, CLS_ID2: el0_undef = 1'b0;
            default:                   el0_undef = 1'b1;
        endcase
    end
endmodule

// File: rtl/hyp_trap_unit.sv
module hyp_trap_unit
    import hyp_trap_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter int EL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       insn_class,
    input  logic             is_write,
    input  logic             cond_pass,
    input  logic             lowpower_entry,
    input  logic             guest_wfi_trap,
    input  logic             guest_wfe_trap,
    input  logic [EL_W-1:0]  cur_el,
    input  logic             el2_enabled,
    input  logic             el3_present,
    input  logic [CFG_W-1:0] hyp_cfg,
    output logic             out_valid,
    output logic             out_exec,
    output logic             out_undef,
    output logic             out_trap,
    output logic [EC_W-1:0]  out_ec
);
    localparam int NWFX = 2;

    verdict_t verdict_d, verdict_q;

    logic            at_el0, at_el1, at_el2, guest_lvl;
    logic            el0_undef, grp_trap, wfx_trap, hvc_off;
    logic [EC_W-1:0] grp_ec;
    logic [NWFX-1:0] wfx_sel, wfx_en, wfx_guest;

    assign at_el0    = (cur_el == EL_W'(0));
    assign at_el1    = (cur_el == EL_W'(1));
    assign at_el2    = (cur_el == EL_W'(2));
    assign guest_lvl = at_el0 | at_el1;

    assign wfx_sel   = {insn_class == CLS_WFE, insn_class == CLS_WFI};
    assign wfx_en    = {hyp_cfg[POS_WFE_TRAP], hyp_cfg[POS_WFI_TRAP]};
    assign wfx_guest = {guest_wfe_trap, guest_wfi_trap};
    assign hvc_off   = hyp_cfg[POS_HVC_OFF] & ~el3_present;

    hyp_trap_wfx #(.NK(NWFX)) u_wfx (
        .kind_sel       (wfx_sel),
        .trap_en        (wfx_en),
        .guest_trap     (wfx_guest),
        .cond_pass      (cond_pass),
        .lowpower_entry (lowpower_entry),
        .wfx_trap       (wfx_trap)
    );

    hyp_trap_sysreg #(.CFG_W(CFG_W)) u_sysreg (
        .cls         (insn_class),
        .is_write    (is_write),
        .el3_present (el3_present),
        .cfg         (hyp_cfg),
        .grp_trap    (grp_trap),
        .grp_ec      (grp_ec)
    );

    hyp_trap_el0 u_el0 (
        .cls       (insn_class),
        .el0_undef (el0_undef)
    );

    // Priority: EL0 undefined, HVC disable, SMC without monitor, EL2 trap, execute
    always_comb begin
        verdict_d = '0;
        if (req_valid) begin
            verdict_d.valid = 1'b1;
            if (at_el0 && el0_undef) begin
                verdict_d.undef = 1'b1;
            end else if (insn_class == CLS_HVC) begin
                if (hvc_off && (at_el2 || (at_el1 && el2_enabled)))
                    verdict_d.undef = 1'b1;
                else
                    verdict_d.exec = 1'b1;
            end else if (insn_class == CLS_SMC && at_el1 && !el3_present) begin
                verdict_d.undef = 1'b1;
            end else if (guest_lvl && el2_enabled && (wfx_trap || grp_trap)) begin
                verdict_d.trap = 1'b1;
                verdict_d.ec   = wfx_trap ? EC_WFX : grp_ec;
            end else begin
                verdict_d.exec = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign out_valid = verdict_q.valid;
    assign out_exec  = verdict_q.exec;
    assign out_undef = verdict_q.undef;
    assign out_trap  = verdict_q.trap;
    assign out_ec    = verdict_q.ec;
endmodule

// File: rtl/hyp_trap_unit_chk.sv
module hyp_trap_unit_chk
    import hyp_trap_pkg::*;
#(
    parameter int EL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [3:0]      insn_class,
    input logic            cond_pass,
    input logic [EL_W-1:0] cur_el,
    input logic            el2_enabled,
    input logic            out_valid,
    input logic            out_exec,
    input logic            out_undef,
    input logic            out_trap,
    input logic [EC_W-1:0] out_ec
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({out_exec, out_undef, out_trap}));

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_exec || out_undef || out_trap));

    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r3_no_el2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !el2_enabled) |=> !out_trap);

    a_r4_el0_smc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && insn_class == CLS_SMC && cur_el == EL_W'(0)) |=> out_undef);

    a_r5_wfx_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (insn_class == CLS_WFI || insn_class == CLS_WFE) && !cond_pass)
        |=> !out_trap);

    a_r12_high_el: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el[EL_W-1] && insn_class != CLS_HVC) |=> out_exec);

    a_r13_ec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_trap) |-> out_ec == '0);
endmodule

bind hyp_trap_unit hyp_trap_unit_chk #(.EL_W(EL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .insn_class  (insn_class),
    .cond_pass   (cond_pass),
    .cur_el      (cur_el),
    .el2_enabled (el2_enabled),
    .out_valid   (out_valid),
    .out_exec    (out_exec),
    .out_undef   (out_undef),
    .out_trap    (out_trap),
    .out_ec      (out_ec)
);

// File: tb/hyp_trap_unit_test.sv
module hyp_trap_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  insn_class = 4'd0;
    logic        is_write = 1'b0;
    logic        cond_pass = 1'b1;
    logic        lowpower_entry = 1'b1;
    logic        guest_wfi_trap = 1'b0;
    logic        guest_wfe_trap = 1'b0;
    logic [1:0]  cur_el = 2'd0;
    logic        el2_enabled = 1'b1;
    logic        el3_present = 1'b1;
    logic [31:0] hyp_cfg = 32'd0;
    logic        out_valid, out_exec, out_undef, out_trap;
    logic [5:0]  out_ec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] flags;   // {exec, undef, trap}
        logic [5:0] ec;
        string      tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [2:0] X_EXEC = 3'b100;
    localparam logic [2:0] X_UNDF = 3'b010;
    localparam logic [2:0] X_TRAP = 3'b001;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyp_trap_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .insn_class(insn_class),
        .is_write(is_write), .cond_pass(cond_pass), .lowpower_entry(lowpower_entry),
        .guest_wfi_trap(guest_wfi_trap), .guest_wfe_trap(guest_wfe_trap),
        .cur_el(cur_el), .el2_enabled(el2_enabled), .el3_present(el3_present),
        .hyp_cfg(hyp_cfg), .out_valid(out_valid), .out_exec(out_exec),
        .out_undef(out_undef), .out_trap(out_trap), .out_ec(out_ec)
    );

    // Monitor: compare each result with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result flags=%b expected none",
                         {out_exec, out_undef, out_trap});
            end else begin
                exp_t e;
                e = sb.pop_front();
                if ({out_exec, out_undef, out_trap} !== e.flags || out_ec !== e.ec) begin
                    errors++;
                    $display("FAIL %s flags=%b ec=%h expected flags=%b ec=%h",
                             e.tag, {out_exec, out_undef, out_trap}, out_ec, e.flags, e.ec);
                end
            end
        end
    end

    task automatic go(input logic [3:0] cls, input logic [1:0] el, input logic [31:0] cfg,
                      input logic [2:0] xf, input logic [5:0] xec, input string tag);
        exp_t e;
        insn_class = cls;
        cur_el     = el;
        hyp_cfg    = cfg;
        req_valid  = 1'b1;
        e.flags = xf; e.ec = xec; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic restore();
        is_write = 1'b0; cond_pass = 1'b1; lowpower_entry = 1'b1;
        guest_wfi_trap = 1'b0; guest_wfe_trap = 1'b0;
        el2_enabled = 1'b1; el3_present = 1'b1;
    endtask

    task automatic idle_check(input string tag);
        checks++;
        if (out_valid || out_exec || out_undef || out_trap || out_ec != 6'd0) begin
            errors++;
            $display("FAIL %s outputs v=%b flags=%b ec=%h expected all zero",
                     tag, out_valid, {out_exec, out_undef, out_trap}, out_ec);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, expected run to complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R2 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R2 after reset");

        // R5 WFx
        go(4'd0, 2'd1, 32'h1 << 13, X_TRAP, 6'h01, "R5 WFI EL1 trap");
        go(4'd1, 2'd0, 32'h1 << 14, X_TRAP, 6'h01, "R5 WFE EL0 trap");
        cond_pass = 1'b0;
        go(4'd0, 2'd1, 32'h1 << 13, X_EXEC, 6'h00, "R5 WFI cond fail");
        cond_pass = 1'b1; lowpower_entry = 1'b0;
        go(4'd1, 2'd1, 32'h1 << 14, X_EXEC, 6'h00, "R5 WFE no lowpower");
        lowpower_entry = 1'b1; guest_wfe_trap = 1'b1;
        go(4'd1, 2'd1, 32'h1 << 14, X_EXEC, 6'h00, "R5 WFE guest trap set");
        guest_wfe_trap = 1'b0;
        go(4'd0, 2'd1, 32'h1 << 14, X_EXEC, 6'h00, "R5 WFI with only WFE bit");

        // R6 SMC
        go(4'd2, 2'd1, 32'h1 << 19, X_TRAP, 6'h13, "R6 SMC EL1 trap");
        go(4'd2, 2'd0, 32'h1 << 19, X_UNDF, 6'h00, "R4 R6 SMC EL0 undef");
        el3_present = 1'b0;
        go(4'd2, 2'd1, 32'h1 << 19, X_UNDF, 6'h00, "R6 SMC no monitor undef");

        // R7 HVC
        go(4'd3, 2'd1, 32'h1 << 29, X_UNDF, 6'h00, "R7 HVC EL1 disabled");
        go(4'd3, 2'd2, 32'h1 << 29, X_UNDF, 6'h00, "R7 HVC EL2 disabled");
        el3_present = 1'b1;
        go(4'd3, 2'd1, 32'h1 << 29, X_EXEC, 6'h00, "R7 HVC bit ignored with monitor");
        restore();

        // R8 virtual-memory controls
        is_write = 1'b1;
        go(4'd9, 2'd1, 32'h1 << 26, X_TRAP, 6'h03, "R8 VM write trap");
        is_write = 1'b0;
        go(4'd9, 2'd1, 32'h1 << 26, X_EXEC, 6'h00, "R8 VM read write-bit only");
        go(4'd9, 2'd1, 32'h1 << 30, X_TRAP, 6'h03, "R8 VM read trap");

        // R4 EL0 priority
        go(4'd7, 2'd0, 32'hFFFF_FFFF, X_UNDF, 6'h00, "R4 set/way EL0 undef");
        go(4'd4, 2'd0, 32'hFFFF_FFFF, X_UNDF, 6'h00, "R4 TLB EL0 undef");

        // R9 maintenance and auxiliary
        go(4'd4, 2'd1, 32'h1 << 25, X_TRAP, 6'h03, "R9 TLB trap");
        go(4'd5, 2'd1, 32'h1 << 24, X_TRAP, 6'h03, "R9 PoU trap");
        go(4'd6, 2'd1, 32'h1 << 23, X_TRAP, 6'h03, "R9 PoC trap");
        go(4'd7, 2'd1, 32'h1 << 22, X_TRAP, 6'h03, "R9 set/way trap");
        go(4'd8, 2'd1, 32'h1 << 21, X_TRAP, 6'h03, "R9 aux trap");
        go(4'd6, 2'd1, 32'h1 << 24, X_EXEC, 6'h00, "R9 PoC with PoU bit only");

        // R10 ID groups 0, 1, 3
        go(4'd14, 2'd1, 32'h1 << 18, X_TRAP, 6'h08, "R10 ID3 fp read");
        go(4'd13, 2'd1, 32'h1 << 18, X_TRAP, 6'h03, "R10 ID3 cp read");
        go(4'd10, 2'd1, 32'h1 << 15, X_TRAP, 6'h03, "R10 ID0 read");
        go(4'd11, 2'd1, 32'h1 << 16, X_TRAP, 6'h03, "R10 ID1 read");
        is_write = 1'b1;
        go(4'd11, 2'd1, 32'h1 << 16, X_EXEC, 6'h00, "R10 ID1 write executes");

        // R11 ID group 2
        go(4'd12, 2'd1, 32'h1 << 17, X_TRAP, 6'h03, "R11 ID2 write trap");
        is_write = 1'b0;
        go(4'd12, 2'd0, 32'h1 << 17, X_TRAP, 6'h03, "R11 ID2 EL0 read trap");
        go(4'd12, 2'd0, 32'h0,       X_EXEC, 6'h00, "R11 ID2 EL0 no bit");

        // R3 EL2 disabled
        el2_enabled = 1'b0;
        go(4'd4, 2'd1, 32'hFFFF_FFFF, X_EXEC, 6'h00, "R3 TLB EL2 off");
        go(4'd0, 2'd0, 32'hFFFF_FFFF, X_EXEC, 6'h00, "R3 WFI EL2 off");
        el2_enabled = 1'b1;

        // R12 / R13 high levels
        go(4'd4,  2'd2, 32'hFFFF_FFFF, X_EXEC, 6'h00, "R12 R13 TLB at EL2");
        go(4'd0,  2'd3, 32'hFFFF_FFFF, X_EXEC, 6'h00, "R12 WFI at EL3");
        go(4'd14, 2'd2, 32'hFFFF_FFFF, X_EXEC, 6'h00, "R12 ID3 at EL2");

        // R1 back-to-back then idle
        go(4'd13, 2'd1, 32'h0, X_EXEC, 6'h00, "R1 R13 ID3 no bit");
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        idle_check("R1 idle after requests");

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 %0d results missing expected 0", sb.size());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule